// File: doc/BRIEF.md
# Bus Slave Register Access Front End

This block sits between a Wishbone-style bus master and a bank of registers. It turns one bus access into a pair of simple internal strobes. The block takes the bus cycle qualifiers, the direction bit, the address and the write data. On the register side it raises a write strobe or a read strobe, together with a held copy of the address and the write data. The master's access completes only when the register side answers: it confirms a write, or it marks the read data as valid.

For the whole access the slave holds stall high. When the register side answers, the slave raises ack and keeps it until the master drops the cycle qualifier. If no answer arrives within a fixed number of cycles, the slave still completes the access, so the bus cannot hang. In that case the access counts as invalid and a read returns zero. Storage, address decoding and error signalling belong to the register bank and are not part of this block.

Top module: `rfe_front`

## Requirements
- R1: After a synchronous reset, stall, ack, the write strobe and the read strobe are all low and the bus read data is zero.
- R2: While idle, both strobes stay low. An access starts only in a cycle where cyc and stb are both high. cyc alone or stb alone leaves stall low.
- R3: stall rises on the clock edge that accepts the access. It stays high in every cycle until the slave has returned to idle.
- R4: When we was high at acceptance, the write strobe rises two edges after acceptance. It stays high until the cycle in which the write confirmation is seen.
- R5: When we was low at acceptance, the read strobe rises two edges after acceptance. It stays high until the cycle in which read-valid is seen.
- R6: The internal address and write data equal the bus values captured at acceptance. Later changes on the bus address or write data do not alter them during the access.
- R7: On the edge after the register side answers, ack goes high and both strobes go low. ack stays high while cyc is high. On the edge after cyc drops, ack and stall go low.
- R8: On a read, the bus read data takes the internal read data present in the cycle read-valid is seen. It holds that value after the internal read data changes.
- R9: If no answer arrives, the strobe stays high for exactly TIMEOUT_CYCLES cycles and the slave then raises ack. A read that ends this way returns zero read data.
- R10: If cyc drops before ack, the access is abandoned. On the next edge stall and both strobes are low, and no ack is given.
- R11: The answer for the other direction is ignored. A write confirmation during a read, or read-valid during a write, neither ends the strobe nor produces ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_stb | input | 1 | Bus strobe, access request |
| bus_we | input | 1 | Direction: 1 write, 0 read |
| bus_adr | input | ADDR_W | Bus address |
| bus_wdat | input | DATA_W | Bus write data |
| bus_rdat | output | DATA_W | Bus read data |
| bus_ack | output | 1 | Access complete, held until cyc drops |
| bus_stall | output | 1 | Slave busy with an access |
| reg_addr | output | ADDR_W | Address captured at acceptance |
| reg_wdata | output | DATA_W | Write data captured at acceptance |
| reg_wr | output | 1 | Write strobe to the register bank |
| reg_rd | output | 1 | Read strobe to the register bank |
| reg_wr_done | input | 1 | Register side confirms the write |
| reg_rd_valid | input | 1 | Register side marks the read data valid |
| reg_rdata | input | DATA_W | Read data from the register bank |

## Verification
Writes and reads are run with answers that come at once and answers that come after several cycles. This shows that the strobe length follows the register side's answer and is not fixed. Bus address and data are changed in mid-access, which separates captured values from values that pass straight through. Reads are run with and without an answer, and the wrong-direction answer is pulsed during a wait. Together these tell a real completion from a timeout and from a stray answer. Cycles that carry only one qualifier, and accesses abandoned early, test the start and abort conditions.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ACTIVE = 3'd1,
        ST_WRITE  = 3'd2,
        ST_READ   = 3'd3,
        ST_DONE   = 3'd4
    } rfe_state_e;

endpackage

// File: rtl/rfe_wait_timer.sv
module rfe_wait_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // Counter runs only while a strobe is out, and restarts from zero otherwise.
    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/rfe_hold_reg.sv
module rfe_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         clear,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (load) begin
            val_d = d;
        end else if (clear) begin
            val_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign q = val_q;

endmodule

// File: rtl/rfe_front.sv
module rfe_front #(
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 32,
    parameter int TIMEOUT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_adr,
    input  logic [DATA_W-1:0] bus_wdat,
    output logic [DATA_W-1:0] bus_rdat,
    output logic              bus_ack,
    output logic              bus_stall,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic              reg_wr_done,
    input  logic              reg_rd_valid,
    input  logic [DATA_W-1:0] reg_rdata
);
    import rfe_pkg::*;

    typedef struct packed {
        rfe_state_e state;
        logic       is_write;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic accept;
    logic waiting;
    logic timed_out;
    logic rd_capture;
    logic rd_zero;

    assign accept  = (ctl_q.state == ST_IDLE) && bus_cyc && bus_stb;
    assign waiting = (ctl_q.state == ST_WRITE) || (ctl_q.state == ST_READ);

    // Next-state logic: each wait state listens only to its own answer.
    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.state    = ST_ACTIVE;
                    ctl_d.is_write = bus_we;
                end
            end
            ST_ACTIVE: begin
                if (!bus_cyc) begin
                    ctl_d.state = ST_IDLE;
                end else if (ctl_q.is_write) begin
                    ctl_d.state = ST_WRITE;
                end else begin
                    ctl_d.state = ST_READ;
                end
            end
            ST_WRITE: begin
                if (!bus_cyc) begin
                    ctl_d.state = ST_IDLE;
                end else if (reg_wr_done || timed_out) begin
                    ctl_d.state = ST_DONE;
                end
            end
            ST_READ: begin
                if (!bus_cyc) begin
                    ctl_d.state = ST_IDLE;
                end else if (reg_rd_valid || timed_out) begin
                    ctl_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                if (!bus_cyc) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{state: ST_IDLE, is_write: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    rfe_wait_timer #(
        .LIMIT (TIMEOUT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (waiting),
        .expired (timed_out)
    );

    rfe_hold_reg #(
        .W (ADDR_W)
    ) u_addr_hold (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .clear (1'b0),
        .d     (bus_adr),
        .q     (reg_addr)
    );

    rfe_hold_reg #(
        .W (DATA_W)
    ) u_wdat_hold (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .clear (1'b0),
        .d     (bus_wdat),
        .q     (reg_wdata)
    );

    // A valid read loads the returned word; a timed-out read loads zero.
    assign rd_capture = (ctl_q.state == ST_READ) && bus_cyc && reg_rd_valid;
    assign rd_zero    = (ctl_q.state == ST_READ) && bus_cyc && timed_out;

    rfe_hold_reg #(
        .W (DATA_W)
    ) u_rdat_hold (
        .clk   (clk),
        .rst   (rst),
        .load  (rd_capture),
        .clear (rd_zero),
        .d     (reg_rdata),
        .q     (bus_rdat)
    );

    assign bus_stall = (ctl_q.state != ST_IDLE);
    assign bus_ack   = (ctl_q.state == ST_DONE);
    assign reg_wr    = (ctl_q.state == ST_WRITE);
    assign reg_rd    = (ctl_q.state == ST_READ);

endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_cyc,
    input logic              bus_stb,
    input logic              bus_ack,
    input logic              bus_stall,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd
);
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bus_ack && !bus_stall && !reg_wr && !reg_rd));

    a_r2_no_start: assert property (@(posedge clk) disable iff (rst)
        (!bus_stall && !(bus_cyc && bus_stb)) |=> !bus_stall);

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    a_r3_strobe_under_stall: assert property (@(posedge clk) disable iff (rst)
        (reg_wr || reg_rd) |-> bus_stall);

    a_r6_addr_steady: assert property (@(posedge clk) disable iff (rst)
        (bus_stall && $past(bus_stall)) |-> $stable(reg_addr));

    a_r7_ack_clean: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> (bus_stall && !reg_wr && !reg_rd));

    a_r7_ack_after_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> $past(reg_wr || reg_rd));

    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && !bus_cyc) |=> (!bus_ack && !bus_stall));

    a_r10_abort: assert property (@(posedge clk) disable iff (rst)
        (bus_stall && !bus_cyc) |=> (!bus_stall && !bus_ack));

endmodule

bind rfe_front rfe_checker #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_cyc   (bus_cyc),
    .bus_stb   (bus_stb),
    .bus_ack   (bus_ack),
    .bus_stall (bus_stall),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd)
);

// File: tb/rfe_front_tb.sv
module rfe_front_tb;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int TMO = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_adr = '0;
    logic [DW-1:0] bus_wdat = '0;
    logic [DW-1:0] bus_rdat;
    logic          bus_ack, bus_stall;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic          reg_wr, reg_rd;
    logic          reg_wr_done = 1'b0, reg_rd_valid = 1'b0;
    logic [DW-1:0] reg_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rfe_front #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYCLES(TMO)) u_dut (
        .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_rdat(bus_rdat), .bus_ack(bus_ack),
        .bus_stall(bus_stall), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wr_done(reg_wr_done),
        .reg_rd_valid(reg_rd_valid), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Starts an access and steps to the first cycle with the strobe out.
    task automatic begin_access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_cyc = 1; bus_stb = 1; bus_we = we; bus_adr = a; bus_wdat = d;
        @(negedge clk);
        chk("R3 stall after accept", bus_stall, 1);
        chk("R4 no strobe yet", {reg_wr, reg_rd}, 0);
        bus_stb = 0; bus_adr = ~a; bus_wdat = ~d; bus_we = ~we;
        @(negedge clk);
        chk("R6 held address", reg_addr, a);
        chk("R6 held wdata", reg_wdata, d);
    endtask

    task automatic end_access();
        @(negedge clk);
        chk("R7 ack held while cyc", bus_ack, 1);
        bus_cyc = 0;
        @(negedge clk);
        chk("R7 released", {bus_ack, bus_stall}, 0);
    endtask

    task automatic t_reset();
        chk("R1 reset outputs", {bus_ack, bus_stall, reg_wr, reg_rd}, 0);
        chk("R1 reset rdat", bus_rdat, 0);
    endtask

    task automatic t_half_qualifier();
        @(negedge clk); bus_cyc = 1; bus_stb = 0;
        @(negedge clk); @(negedge clk);
        chk("R2 cyc alone", {bus_stall, reg_wr, reg_rd}, 0);
        bus_cyc = 0; bus_stb = 1;
        @(negedge clk); @(negedge clk);
        chk("R2 stb alone", {bus_stall, reg_wr, reg_rd}, 0);
        bus_stb = 0;
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int waitn);
        begin_access(1'b1, a, d);
        chk("R4 write strobe", {reg_wr, reg_rd}, 2'b10);
        for (int i = 0; i < waitn; i++) begin
            if (i == 1) reg_rd_valid = 1;
            @(negedge clk);
            reg_rd_valid = 0;
            chk("R4 strobe held", {reg_wr, bus_ack}, 2'b10);
            if (i == 1) chk("R11 read-valid ignored in write", bus_ack, 0);
        end
        reg_wr_done = 1;
        @(negedge clk);
        reg_wr_done = 0;
        chk("R7 ack after confirm", {bus_ack, reg_wr}, 2'b10);
        end_access();
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] v, input int waitn);
        begin_access(1'b0, a, 32'h0);
        chk("R5 read strobe", {reg_wr, reg_rd}, 2'b01);
        for (int i = 0; i < waitn; i++) begin
            if (i == 0) reg_wr_done = 1;
            @(negedge clk);
            reg_wr_done = 0;
            chk("R5 strobe held", {reg_rd, bus_ack}, 2'b10);
            if (i == 0) chk("R11 write confirm ignored in read", bus_ack, 0);
        end
        reg_rd_valid = 1; reg_rdata = v;
        @(negedge clk);
        reg_rd_valid = 0; reg_rdata = ~v;
        chk("R7 ack after valid", {bus_ack, reg_rd}, 2'b10);
        chk("R8 read data", bus_rdat, v);
        @(negedge clk);
        chk("R8 read data held", bus_rdat, v);
        bus_cyc = 0;
        @(negedge clk);
        chk("R7 released", {bus_ack, bus_stall}, 0);
    endtask

    task automatic t_timeout(input logic we);
        int hi;
        hi = 0;
        begin_access(we, 8'h3C, 32'h5555_AAAA);
        for (int i = 0; i < 100 && !bus_ack; i++) begin
            if (reg_wr || reg_rd) hi++;
            @(negedge clk);
        end
        chk("R9 strobe length", hi, TMO);
        chk("R9 ack on timeout", bus_ack, 1);
        if (!we) chk("R9 zero read data", bus_rdat, 0);
        end_access();
    endtask

    task automatic t_abort();
        begin_access(1'b0, 8'h11, 32'h0);
        bus_cyc = 0;
        @(negedge clk);
        chk("R10 abort", {bus_stall, bus_ack, reg_wr, reg_rd}, 0);
        @(negedge clk);
        chk("R10 no late ack", bus_ack, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_half_qualifier();
        t_write(8'hA5, 32'hDEAD_BEEF, 0);
        t_write(8'h07, 32'h0000_0013, 5);
        t_read(8'h42, 32'h1234_5678, 0);
        t_read(8'hF0, 32'hCAFE_0001, 4);
        t_timeout(1'b1);
        t_timeout(1'b0);
        t_abort();
        finish_run();
    end
endmodule